// File: doc/BRIEF.md
# Protected System Clock Control Register

This block holds an 8-bit clock control word. The word selects the system clock source and the main clock division ratio. It also raises a request to stop all clocks and sets an oscillator drive-strength level.

Software writes the word through a plain write port. A write lands only while a separate protect-enable input is 1. Some fields are refused, or left without effect, depending on other clock-control state, and one bit is set by hardware.

The clocks enter the block as single-cycle enables sampled on the block clock. The block sends out one system clock enable. That enable is the chosen source, divided by the chosen ratio. The pads, the PLL and the wake-up path live elsewhere.

Top module: `sysclk_ctrl_reg`

## Requirements
- R1: After reset, `ctl_q` reads 8'h20, so `drive_hi`=1 and `stop_req`=0. The ratio is 1 and the source is the main clock, so `sys_ce` equals `main_ce` in every cycle.
- R2: A write (`wr_en`=1) changes nothing unless `protect_ok`=1 in the same cycle. An accepted write is visible on `ctl_q` one cycle later.
- R3: Bits 4:2 of `ctl_q` always read 0, whatever value is written.
- R4: Bit 0 is the stop bit and drives `stop_req`. While it is 1, `sys_ce` is 0. Writing 0 to bit 0 clears it.
- R5: While `wdt_onchip`=1, a write leaves bit 0 at its old value.
- R6: A write of 1 to bit 0 is refused, keeping the old bit 0, in two cases: when the same write leaves bit 1 at 1, or when `osc_stop_det_en`=1.
- R7: Bit 1 takes a written 1 only if the PLL is ready; otherwise bit 1 becomes 0. The PLL is ready when, on an earlier cycle, `pll_on`=1 and `pll_settled`=1 were seen together, and `pll_on` has stayed 1 since then. Dropping `pll_on` clears readiness.
- R8: The prescaler counts `pll_ce` when bit 1 is 1, `low_speed_sel`=0 and `onchip_osc_sel`=0. In every other case it counts `main_ce`.
- R9: When `div_gate`=0, bits 7:6 set the ratio: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 16. When `div_gate`=1, the ratio is 8.
- R10: Bit 5 is the drive-strength bit and drives `drive_hi`. Hardware forces it to 1 in two cases: when a write sets the stop bit while `low_speed_sel`=0, and in any cycle where `main_osc_off`=1 and `low_speed_sel`=1. Otherwise it takes the written value.
- R11: `sys_ce` pulses for one cycle on every N-th counted source enable, where N is the ratio. If the ratio or the effective source differs from the previous cycle, that cycle gives no pulse and the count restarts from zero. The next pulse then comes only after N fresh source enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Write data |
| protect_ok | input | 1 | Protect enable; writes land only when 1 |
| main_ce | input | 1 | Main clock enable tick |
| pll_ce | input | 1 | PLL clock enable tick |
| pll_on | input | 1 | PLL running |
| pll_settled | input | 1 | PLL lock-time elapsed |
| osc_stop_det_en | input | 1 | Oscillation-stop detection active |
| wdt_onchip | input | 1 | Watchdog clocked from on-chip oscillator |
| low_speed_sel | input | 1 | Low-speed clock selected elsewhere |
| onchip_osc_sel | input | 1 | On-chip oscillator selected elsewhere |
| div_gate | input | 1 | 1 = ignore bits 7:6, divide by 8 |
| main_osc_off | input | 1 | Main oscillator being turned off |
| ctl_q | output | 8 | Current control word |
| sys_ce | output | 1 | System clock enable |
| stop_req | output | 1 | Stop-all-clocks request |
| drive_hi | output | 1 | Oscillator drive strength high |

## Verification
Two collisions can fall in the same clock:
- A write that sets the stop bit, and the hardware override of the drive bit. The bench writes a 0 in bit 5 together with a 1 in bit 0, with `low_speed_sel` both low and high. A model written from the rules judges whether bit 5 is forced.
- A ratio change, and a source enable that would have ended the old count. The bench rewrites bits 7:6 while `main_ce` ticks every cycle. The model then expects no pulse in the change cycle and a full fresh count afterwards.

Random stretches make these collisions land at arbitrary phases.

// File: rtl/sysclk_ctrl_reg.sv
module sysclk_ctrl_reg #(
  parameter int          CNT_W     = 4,
  parameter logic [7:0]  RST_VAL   = 8'h20,
  parameter int          GATED_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       protect_ok,
  input  logic       main_ce,
  input  logic       pll_ce,
  input  logic       pll_on,
  input  logic       pll_settled,
  input  logic       osc_stop_det_en,
  input  logic       wdt_onchip,
  input  logic       low_speed_sel,
  input  logic       onchip_osc_sel,
  input  logic       div_gate,
  input  logic       main_osc_off,
  output logic [7:0] ctl_q,
  output logic       sys_ce,
  output logic       stop_req,
  output logic       drive_hi
);

  localparam logic [CNT_W-1:0] GATED_M1 = CNT_W'(GATED_DIV - 1);

  logic [7:0]       ctl;
  logic             pll_ok;
  logic [CNT_W-1:0] cnt, ratio_m1, ratio_q;
  logic             src_pll, src_q, tick, chg, wr_ok;
  logic             nb1, nb0, stop_acc, nb5;

  assign wr_ok    = wr_en & protect_ok;
  assign nb1      = wr_data[1] & pll_ok;
  assign nb0      = wdt_onchip ? ctl[0] :
                    (wr_data[0] & (nb1 | osc_stop_det_en)) ? ctl[0] : wr_data[0];
  assign stop_acc = nb0 & ~ctl[0];
  assign nb5      = wr_data[5] | (stop_acc & ~low_speed_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl    <= RST_VAL;
      pll_ok <= 1'b0;
    end else begin
      if (wr_ok)
        ctl <= {wr_data[7:6], nb5 | (main_osc_off & low_speed_sel), 3'b000, nb1, nb0};
      else if (main_osc_off & low_speed_sel)
        ctl[5] <= 1'b1;
      pll_ok <= pll_on & (pll_ok | pll_settled);
    end
  end

  assign src_pll = ctl[1] & ~low_speed_sel & ~onchip_osc_sel;
  assign tick    = src_pll ? pll_ce : main_ce;

  always_comb begin
    if (div_gate) ratio_m1 = GATED_M1;
    else begin
      case (ctl[7:6])
        2'b00:   ratio_m1 = CNT_W'(0);
        2'b01:   ratio_m1 = CNT_W'(1);
        2'b10:   ratio_m1 = CNT_W'(3);
        default: ratio_m1 = CNT_W'(15);
      endcase
    end
  end

  assign chg = (ratio_m1 != ratio_q) | (src_pll != src_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      ratio_q <= '0;
      src_q   <= 1'b0;
    end else begin
      ratio_q <= ratio_m1;
      src_q   <= src_pll;
      if (chg | ctl[0])       cnt <= '0;
      else if (tick)          cnt <= (cnt == ratio_m1) ? '0 : cnt + 1'b1;
    end
  end

  assign sys_ce   = tick & (cnt == ratio_m1) & ~ctl[0] & ~chg;
  assign ctl_q    = ctl;
  assign stop_req = ctl[0];
  assign drive_hi = ctl[5];

endmodule

module sysclk_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       protect_ok,
  input logic       wdt_onchip,
  input logic       osc_stop_det_en,
  input logic       low_speed_sel,
  input logic [7:0] ctl_q,
  input logic       sys_ce,
  input logic       stop_req,
  input logic       drive_hi
);
  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[4:2] == 3'b000);
  assert_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !protect_ok |=> (ctl_q[7:6] == $past(ctl_q[7:6])) && (ctl_q[1:0] == $past(ctl_q[1:0])));
  assert_stop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !sys_ce);
  assert_wdt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdt_onchip) |=> stop_req == $past(stop_req));
  assert_stop_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> (!ctl_q[1] && !$past(osc_stop_det_en)));
  assert_drive_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stop_req) && !$past(low_speed_sel)) |-> drive_hi);
endmodule

bind sysclk_ctrl_reg sysclk_ctrl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .protect_ok(protect_ok),
  .wdt_onchip(wdt_onchip), .osc_stop_det_en(osc_stop_det_en),
  .low_speed_sel(low_speed_sel), .ctl_q(ctl_q), .sys_ce(sys_ce),
  .stop_req(stop_req), .drive_hi(drive_hi)
);

// File: tb/test_sysclk_ctrl_reg.sv
module test_sysclk_ctrl_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, protect_ok = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic main_ce = 1'b1, pll_ce = 1'b0, pll_on = 1'b0, pll_settled = 1'b0;
  logic osc_stop_det_en = 1'b0, wdt_onchip = 1'b0, low_speed_sel = 1'b0;
  logic onchip_osc_sel = 1'b0, div_gate = 1'b0, main_osc_off = 1'b0;
  logic [7:0] ctl_q;
  logic sys_ce, stop_req, drive_hi;

  always #10 clk = ~clk;

  sysclk_ctrl_reg i_sysclk_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .protect_ok(protect_ok), .main_ce(main_ce), .pll_ce(pll_ce),
    .pll_on(pll_on), .pll_settled(pll_settled), .osc_stop_det_en(osc_stop_det_en),
    .wdt_onchip(wdt_onchip), .low_speed_sel(low_speed_sel),
    .onchip_osc_sel(onchip_osc_sel), .div_gate(div_gate),
    .main_osc_off(main_osc_off), .ctl_q(ctl_q), .sys_ce(sys_ce),
    .stop_req(stop_req), .drive_hi(drive_hi));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  int m_reg, m_cnt, m_ratio_q, m_src_q, m_pll_ok;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int ratio_of();
    if (div_gate) return 8;
    case (m_reg[7:6])
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 16;
    endcase
  endfunction

  function automatic int src_of();
    return (m_reg[1] && !low_speed_sel && !onchip_osc_sel) ? 1 : 0;
  endfunction

  function automatic int exp_ce();
    int tk, ch;
    tk = src_of() ? int'(pll_ce) : int'(main_ce);
    ch = (ratio_of() != m_ratio_q) || (src_of() != m_src_q);
    return (tk && m_cnt == ratio_of() - 1 && !m_reg[0] && !ch) ? 1 : 0;
  endfunction

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int nreg, b1, b0, tk, ch, r;
    if (!rst_n) begin
      m_reg = 32'h20; m_cnt = 0; m_ratio_q = 1; m_src_q = 0; m_pll_ok = 0;
      return;
    end
    r  = ratio_of();
    tk = src_of() ? int'(pll_ce) : int'(main_ce);
    ch = (r != m_ratio_q) || (src_of() != m_src_q);
    nreg = m_reg;
    if (wr_en && protect_ok) begin
      b1 = (wr_data[1] && m_pll_ok) ? 1 : 0;
      if (wdt_onchip) b0 = m_reg[0];
      else if (wr_data[0] && (b1 || osc_stop_det_en)) b0 = m_reg[0];
      else b0 = wr_data[0];
      nreg = (wr_data[7:6] << 6) | (wr_data[5] << 5) | (b1 << 1) | b0;
      if (b0 && !m_reg[0] && !low_speed_sel) nreg = nreg | 32'h20;
    end
    if (main_osc_off && low_speed_sel) nreg = nreg | 32'h20;
    if (ch || m_reg[0]) m_cnt = 0;
    else if (tk) m_cnt = (m_cnt == r - 1) ? 0 : m_cnt + 1;
    m_ratio_q = r;
    m_src_q = src_of();
    m_pll_ok = (pll_on && (m_pll_ok || pll_settled)) ? 1 : 0;
    m_reg = nreg;
  endtask

  task automatic step();
    #5;
    cmp("ctl_q", ctl_q, m_reg);
    cmp("sys_ce", sys_ce, exp_ce());
    cmp("stop_req", stop_req, m_reg[0]);
    cmp("drive_hi", drive_hi, m_reg[5]);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0;
  endtask

  task automatic run_rand_ce(int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      main_ce = lfsr[0]; pll_ce = lfsr[3];
      step();
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    model_edge();
    @(negedge clk);
    cur_tag = "R1"; run(3);
    rst_n = 1'b1;
    run_rand_ce(20);

    cur_tag = "R2"; main_ce = 1'b1;
    protect_ok = 1'b0; wr(8'hC3); run(4);
    protect_ok = 1'b1;

    cur_tag = "R3"; wr(8'h1C); run(3); wr(8'h3C); run(2);

    cur_tag = "R9";
    wr(8'h40); run(12); wr(8'h80); run(12); wr(8'hC0); run(40);
    div_gate = 1'b1; run(20); div_gate = 1'b0; run_rand_ce(30);

    cur_tag = "R11"; main_ce = 1'b1;
    wr(8'hC0); run(7); wr(8'h40); run(6); wr(8'h80); run(2); wr(8'h00); run(3);
    div_gate = 1'b1; run(3); div_gate = 1'b0; run(4);

    cur_tag = "R7";
    wr(8'h02); run(2);
    pll_on = 1'b1; wr(8'h02); run(2);
    pll_settled = 1'b1; step(); pll_settled = 1'b0; run(2);
    wr(8'h02); run(2);

    cur_tag = "R8";
    for (int i = 0; i < 60; i++) begin
      pll_ce = (i % 3 == 0); main_ce = (i % 2 == 0);
      low_speed_sel = (i >= 20 && i < 30); onchip_osc_sel = (i >= 40 && i < 48);
      step();
    end
    low_speed_sel = 1'b0; onchip_osc_sel = 1'b0;

    cur_tag = "R6";
    wr(8'h03); run(2);
    wr(8'h00); run(2);
    osc_stop_det_en = 1'b1; wr(8'h01); run(2); osc_stop_det_en = 1'b0;

    cur_tag = "R5";
    wdt_onchip = 1'b1; wr(8'h01); run(2); wdt_onchip = 1'b0;

    cur_tag = "R4"; main_ce = 1'b1;
    wr(8'h01); run(6); wr(8'h00); run(3);

    cur_tag = "R10";
    low_speed_sel = 1'b1; wr(8'h01); run(2); wr(8'h00); run(1);
    main_osc_off = 1'b1; step(); main_osc_off = 1'b0; run(2);
    wr(8'h00); low_speed_sel = 1'b0;
    main_osc_off = 1'b1; run(2); main_osc_off = 1'b0;

    cur_tag = "R11";
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      main_ce = lfsr[0]; pll_ce = lfsr[1];
      pll_on = lfsr[2] | lfsr[9]; pll_settled = lfsr[3] & lfsr[4];
      osc_stop_det_en = lfsr[5] & lfsr[6] & lfsr[7];
      wdt_onchip = lfsr[8] & lfsr[11];
      low_speed_sel = lfsr[12] & lfsr[13]; onchip_osc_sel = lfsr[14] & lfsr[15] & lfsr[2];
      div_gate = lfsr[4] & lfsr[10]; main_osc_off = lfsr[6] & lfsr[12] & lfsr[1];
      protect_ok = lfsr[7] | lfsr[3];
      wr_en = (lfsr[15:12] == 4'h5); wr_data = {lfsr[11:4]} & 8'hFE | {7'd0, lfsr[0] & lfsr[9]};
      step();
    end
    wr_en = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule